// File: doc/BRIEF.md
# Memory Write Error Injector

This block sits in the write path of one memory controller channel. It corrupts outgoing check bits on purpose so that the error detection and correction logic downstream can be tested. Software programs three registers through a simple write port. The first is an address-match register, where each address field (dimm, rank, bank, page, column) has its own wildcard bit. The second is a 32-bit check-bit flip mask. The third is a control word. Writing the control word arms the injector.

Each request carries its dimm, rank, bank, page and column, a write/read flag and 32 check bits. Check bits 15:0 protect the lower 32-byte half of the cacheline and bits 31:16 protect the upper half. On an armed write that matches every non-wildcard field, the block does one or both of the following:
- It XORs the matching 16-bit slice of the flip mask into each selected half.
- It raises an address-parity error flag.

The result leaves one cycle later together with a one-cycle pulse marking the corrupted write. In one-shot mode the injector disarms after its first hit. In repeat mode it keeps corrupting until software rewrites the control word.

Top module: `wr_err_injector`

## Requirements
- R1: While `rst_n` is low, the following are all cleared on the next clock edge: `out_valid`, `out_check`, `out_addr_par_err`, `inject_fired` and `armed`. The flip mask and control word reset to zero. The match register resets with all five wildcard bits set, so that once armed any address matches.
- R2: Every request appears on `out_valid`/`out_check` exactly one cycle after it is presented on `req_valid`/`req_check`. Its check bits are unchanged unless it is corrupted.
- R3: Match register layout:
  - column in bits 13:0, page in bits 29:14, bank in bits 33:30;
  - wildcard bits: 37 for column, 38 for page, 39 for bank, 40 for rank, 41 for dimm.
  
  A request hits only if every field whose wildcard bit is clear equals the request's field.
- R4: With `cfg_wide_dimm`=1, dimm is bits 36:35 and rank is bit 34, which is compared with the request's rank bit 0. With `cfg_wide_dimm`=0, dimm is bit 36, which is compared with the request's dimm bit 0, and rank is bits 35:34.
- R5: Control word layout (`reg_sel`=2): bit 0 selects repeat mode, bits 2:1 select the halves, bit 3 requests check-bit corruption and bit 4 requests an address-parity error. A control write leaves `armed` set on the next cycle exactly when bit 3 or bit 4 of the written value is 1.
- R6: A write to the match register (`reg_sel`=0) or to the flip mask (`reg_sel`=1) clears `armed` on the next cycle. A request after that write is not corrupted until the control word is written again. `reg_sel`=3 writes nothing.
- R7: Only requests with `req_write`=1 can be corrupted. A read passes through with its check bits unchanged and does not disarm a one-shot injector.
- R8: With bit 0 clear, the first matching write is corrupted and `armed` is low from the next cycle. Later matching writes pass unchanged.
- R9: With bit 0 set, every matching write is corrupted. This continues until the control word is rewritten with bits 3 and 4 clear.
- R10: The half select decides which slices are flipped:
  - 01: bits 15:0 XOR mask 15:0;
  - 10: bits 31:16 XOR mask 31:16;
  - 11: both halves;
  - 00: neither half, although the write still counts as an injection.
- R11: With bit 4 set, a corrupted write raises `out_addr_par_err` in its output cycle. The flag is never raised otherwise.
- R12: `inject_fired` is high for exactly the output cycle of each corrupted write and is low for every other output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wide_dimm | input | 1 | Channel holds more than two dimms (selects the dimm/rank layout) |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 match, 1 flip mask, 2 control, 3 none |
| reg_wdata | input | 42 | Register write data |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | Request is a write |
| req_dimm | input | 2 | Request dimm |
| req_rank | input | 2 | Request rank |
| req_bank | input | 4 | Request bank |
| req_page | input | 16 | Request page (row) |
| req_col | input | 14 | Request column |
| req_check | input | 32 | Request check bits |
| out_valid | output | 1 | Request leaving the block |
| out_check | output | 32 | Check bits after optional corruption |
| out_addr_par_err | output | 1 | Address-parity error injected on this request |
| inject_fired | output | 1 | This request was corrupted |
| armed | output | 1 | Injector armed |

## Verification
Register writes take effect at the clock edge that samples them. The `armed` flag, and any request presented in the following cycle, therefore already see the new value. Every request result (valid, check bits, parity flag, fired pulse) passes through one register stage and is due at the edge after the request is sampled. The bench drives every input on the falling edge and reads every output one full cycle later on the next falling edge. Each comparison therefore lands on the single cycle in which the result is defined. A second request is presented only after the previous one has been checked, so a one-shot disarm is observed before the next hit is attempted.

// File: rtl/inj_pkg.sv
// Package: shared field positions, widths and types of the write error injector.
// Assumes the match register layout is fixed by the downstream decoder.
package inj_pkg;
    localparam int COL_W       = 14;
    localparam int PAGE_W      = 16;
    localparam int BANK_W      = 4;
    localparam int DIMM_W      = 2;
    localparam int RANK_W      = 2;
    localparam int CTRL_W      = 5;
    localparam int N_FIELDS    = 5;

    localparam int COL_LSB     = 0;
    localparam int PAGE_LSB    = COL_LSB + COL_W;
    localparam int BANK_LSB    = PAGE_LSB + PAGE_W;
    localparam int RANK_LSB    = BANK_LSB + BANK_W;
    localparam int DIMM_HI     = RANK_LSB + 2;
    localparam int WILD_LSB    = DIMM_HI + 1;
    localparam int MATCH_W     = WILD_LSB + N_FIELDS;

    // wildcard bit index inside the wildcard group
    localparam int WI_COL      = 0;
    localparam int WI_PAGE     = 1;
    localparam int WI_BANK     = 2;
    localparam int WI_RANK     = 3;
    localparam int WI_DIMM     = 4;

    localparam logic [MATCH_W-1:0] MATCH_RESET =
        {{N_FIELDS{1'b1}}, {(MATCH_W-N_FIELDS){1'b0}}};

    typedef enum logic [1:0] {
        SEL_MATCH = 2'd0,
        SEL_FLIP  = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    // packed MSB first: bit4 parity, bit3 ecc, bits2:1 halves, bit0 repeat
    typedef struct packed {
        logic       par;
        logic       ecc;
        logic [1:0] half;
        logic       rep;
    } ctrl_t;

    typedef struct packed {
        logic [DIMM_W-1:0] dimm;
        logic [RANK_W-1:0] rank;
        logic [BANK_W-1:0] bank;
        logic [PAGE_W-1:0] page;
        logic [COL_W-1:0]  col;
    } addr_t;
endpackage

// File: rtl/inj_regs.sv
// Module: injector register file and arm state.
// Holds match, flip mask and control; arms on a control write that requests
// an error, disarms on other register writes and after a one-shot hit.
// Assumes CHK_W <= MATCH_W so the flip mask fits the write data bus.
module inj_regs
    import inj_pkg::*;
#(
    parameter int CHK_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  reg_sel_e           reg_sel,
    input  logic [MATCH_W-1:0] reg_wdata,
    input  logic               fire,
    output logic [MATCH_W-1:0] match_q,
    output logic [CHK_W-1:0]   flip_q,
    output ctrl_t              ctrl_q,
    output logic               armed_q
);
    logic  reg_hit;
    ctrl_t ctrl_new;

    // Purpose: decode a write that lands on a real register.
    always_comb begin
        reg_hit  = reg_wr_en && (reg_sel != SEL_NONE);
        ctrl_new = ctrl_t'(reg_wdata[CTRL_W-1:0]);
    end

    // Purpose: register storage and arm/disarm sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= MATCH_RESET;
            flip_q  <= '0;
            ctrl_q  <= '0;
            armed_q <= 1'b0;
        end else if (reg_hit) begin
            unique case (reg_sel)
                SEL_MATCH: begin
                    match_q <= reg_wdata;
                    armed_q <= 1'b0;
                end
                SEL_FLIP: begin
                    flip_q  <= reg_wdata[CHK_W-1:0];
                    armed_q <= 1'b0;
                end
                SEL_CTRL: begin
                    ctrl_q  <= ctrl_new;
                    armed_q <= ctrl_new.ecc | ctrl_new.par;
                end
                default: ;
            endcase
        end else if (fire && !ctrl_q.rep) begin
            armed_q <= 1'b0;
        end
    end
endmodule

// File: rtl/inj_addr_match.sv
// Module: per-field address comparator with wildcards.
// Unpacks the match register according to the dimm layout and reports a hit
// when every field is either wildcarded or equal. Purely combinational.
module inj_addr_match
    import inj_pkg::*;
(
    input  logic [MATCH_W-1:0] match_q,
    input  logic               wide_dimm,
    input  addr_t              req_addr,
    output logic               hit
);
    logic [N_FIELDS-1:0] wild;
    logic [N_FIELDS-1:0] eq;
    logic [DIMM_W-1:0]   m_dimm;
    logic [RANK_W-1:0]   m_rank;
    logic [DIMM_W-1:0]   r_dimm;
    logic [RANK_W-1:0]   r_rank;

    // Purpose: unpack dimm and rank for the configured layout.
    always_comb begin
        if (wide_dimm) begin
            m_dimm = match_q[DIMM_HI -: 2];
            r_dimm = req_addr.dimm;
            m_rank = {1'b0, match_q[RANK_LSB]};
            r_rank = {1'b0, req_addr.rank[0]};
        end else begin
            m_dimm = {1'b0, match_q[DIMM_HI]};
            r_dimm = {1'b0, req_addr.dimm[0]};
            m_rank = match_q[RANK_LSB +: RANK_W];
            r_rank = req_addr.rank;
        end
    end

    // Purpose: per-field equality and wildcard combine.
    always_comb begin
        wild        = match_q[WILD_LSB +: N_FIELDS];
        eq[WI_COL]  = match_q[COL_LSB  +: COL_W]  == req_addr.col;
        eq[WI_PAGE] = match_q[PAGE_LSB +: PAGE_W] == req_addr.page;
        eq[WI_BANK] = match_q[BANK_LSB +: BANK_W] == req_addr.bank;
        eq[WI_RANK] = m_rank == r_rank;
        eq[WI_DIMM] = m_dimm == r_dimm;
        hit         = &(wild | eq);
    end
endmodule

// File: rtl/inj_corrupt.sv
// Module: output stage that applies the flip mask per cacheline half.
// Assumes CHK_W is even; the lower half of the check bits covers the lower
// 32-byte half of the line. Adds one register stage of latency.
module inj_corrupt
    import inj_pkg::*;
#(
    parameter int CHK_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [CHK_W-1:0] req_check,
    input  logic             fire,
    input  ctrl_t            ctrl_q,
    input  logic [CHK_W-1:0] flip_q,
    output logic             out_valid,
    output logic [CHK_W-1:0] out_check,
    output logic             out_par_err,
    output logic             out_fired
);
    localparam int HALF_W  = CHK_W / 2;
    localparam int N_HALF  = 2;

    logic [CHK_W-1:0] flip_eff;

    // Purpose: build the effective flip vector, one slice per half.
    for (genvar h = 0; h < N_HALF; h++) begin : g_half
        assign flip_eff[h*HALF_W +: HALF_W] =
            (fire && ctrl_q.ecc && ctrl_q.half[h]) ? flip_q[h*HALF_W +: HALF_W]
                                                   : '0;
    end

    // Purpose: register the request result and the injection flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_check   <= '0;
            out_par_err <= 1'b0;
            out_fired   <= 1'b0;
        end else begin
            out_valid   <= req_valid;
            out_check   <= req_check ^ flip_eff;
            out_par_err <= fire && ctrl_q.par;
            out_fired   <= fire;
        end
    end
endmodule

// File: rtl/wr_err_injector.sv
// Module: memory write error injector, top level.
// Ties the register file, the address comparator and the corruption stage.
// Assumes one request per cycle and a single channel.
module wr_err_injector
    import inj_pkg::*;
#(
    parameter int CHK_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wide_dimm,
    input  logic                reg_wr_en,
    input  logic [1:0]          reg_sel,
    input  logic [MATCH_W-1:0]  reg_wdata,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [DIMM_W-1:0]   req_dimm,
    input  logic [RANK_W-1:0]   req_rank,
    input  logic [BANK_W-1:0]   req_bank,
    input  logic [PAGE_W-1:0]   req_page,
    input  logic [COL_W-1:0]    req_col,
    input  logic [CHK_W-1:0]    req_check,
    output logic                out_valid,
    output logic [CHK_W-1:0]    out_check,
    output logic                out_addr_par_err,
    output logic                inject_fired,
    output logic                armed
);
    logic [MATCH_W-1:0] match_q;
    logic [CHK_W-1:0]   flip_q;
    ctrl_t              ctrl_q;
    logic               addr_hit;
    logic               fire;
    logic               ctrl_rep;
    addr_t              req_addr;

    // Purpose: gather the request address and decide whether to inject.
    always_comb begin
        req_addr = '{dimm: req_dimm, rank: req_rank, bank: req_bank,
                     page: req_page, col: req_col};
        fire     = armed && req_valid && req_write && addr_hit;
        ctrl_rep = ctrl_q.rep;
    end

    inj_regs #(.CHK_W(CHK_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_sel   (reg_sel_e'(reg_sel)),
        .reg_wdata (reg_wdata),
        .fire      (fire),
        .match_q   (match_q),
        .flip_q    (flip_q),
        .ctrl_q    (ctrl_q),
        .armed_q   (armed)
    );

    inj_addr_match u_match (
        .match_q   (match_q),
        .wide_dimm (cfg_wide_dimm),
        .req_addr  (req_addr),
        .hit       (addr_hit)
    );

    inj_corrupt #(.CHK_W(CHK_W)) u_corrupt (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_check   (req_check),
        .fire        (fire),
        .ctrl_q      (ctrl_q),
        .flip_q      (flip_q),
        .out_valid   (out_valid),
        .out_check   (out_check),
        .out_par_err (out_addr_par_err),
        .out_fired   (inject_fired)
    );
endmodule

// File: rtl/inj_checker.sv
// Module: assertion checker for the write error injector, bound to the top.
module inj_checker #(
    parameter int CHK_W = 32,
    parameter int WD_W  = 42
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr_en,
    input logic [1:0]       reg_sel,
    input logic [WD_W-1:0]  reg_wdata,
    input logic             req_valid,
    input logic             req_write,
    input logic [CHK_W-1:0] req_check,
    input logic             out_valid,
    input logic [CHK_W-1:0] out_check,
    input logic             out_addr_par_err,
    input logic             inject_fired,
    input logic             armed,
    input logic             ctrl_rep
);
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(req_valid));                                      // R2

    AST_CTRL_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_wr_en && reg_sel == 2'd2) |->
        armed == $past(reg_wdata[3] | reg_wdata[4]));                        // R5

    AST_CFG_WRITE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_wr_en && (reg_sel == 2'd0 || reg_sel == 2'd1)) |-> !armed); // R6

    AST_FIRE_ONLY_ARMED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        inject_fired |-> $past(armed && req_valid && req_write));            // R7

    AST_READ_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && !req_write) |-> out_check == $past(req_check));   // R7

    AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        (inject_fired && !$past(ctrl_rep) && !$past(reg_wr_en)) |-> !armed); // R8

    AST_PARITY_NEEDS_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        out_addr_par_err |-> inject_fired);                                  // R11

    AST_FIRE_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        inject_fired |-> out_valid);                                         // R12
endmodule

bind wr_err_injector inj_checker #(.CHK_W(CHK_W), .WD_W(inj_pkg::MATCH_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .reg_wr_en        (reg_wr_en),
    .reg_sel          (reg_sel),
    .reg_wdata        (reg_wdata),
    .req_valid        (req_valid),
    .req_write        (req_write),
    .req_check        (req_check),
    .out_valid        (out_valid),
    .out_check        (out_check),
    .out_addr_par_err (out_addr_par_err),
    .inject_fired     (inject_fired),
    .armed            (armed),
    .ctrl_rep         (ctrl_rep)
);

// File: tb/tb_wr_err_injector.sv
module tb_wr_err_injector;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wide_dimm;
    logic        reg_wr_en;
    logic [1:0]  reg_sel;
    logic [41:0] reg_wdata;
    logic        req_valid, req_write;
    logic [1:0]  req_dimm, req_rank;
    logic [3:0]  req_bank;
    logic [15:0] req_page;
    logic [13:0] req_col;
    logic [31:0] req_check;
    logic        out_valid, out_addr_par_err, inject_fired, armed;
    logic [31:0] out_check;

    int n_checks = 0;
    int n_fail   = 0;

    localparam logic [31:0] MASK = 32'h00FF_0F00;

    typedef struct packed {
        logic        wr;
        logic [1:0]  dimm;
        logic [1:0]  rank;
        logic [3:0]  bank;
        logic [15:0] page;
        logic [13:0] col;
        logic [31:0] chk;
        logic        fire;
    } vec_t;

    // Table: narrow layout, match dimm=1, bank=5, col=0x123, rank/page wild.
    localparam vec_t VECS [8] = '{
        '{1'b1, 2'd1, 2'd2, 4'd5, 16'h1234, 14'h123, 32'hAAAA_5555, 1'b1},
        '{1'b0, 2'd1, 2'd2, 4'd5, 16'h1234, 14'h123, 32'hAAAA_5555, 1'b0},
        '{1'b1, 2'd0, 2'd2, 4'd5, 16'h1234, 14'h123, 32'h1234_5678, 1'b0},
        '{1'b1, 2'd1, 2'd2, 4'd4, 16'h1234, 14'h123, 32'h0F0F_F0F0, 1'b0},
        '{1'b1, 2'd1, 2'd2, 4'd5, 16'h1234, 14'h124, 32'hFFFF_0000, 1'b0},
        '{1'b1, 2'd1, 2'd3, 4'd5, 16'hFFFF, 14'h123, 32'h0000_0000, 1'b1},
        '{1'b1, 2'd3, 2'd0, 4'd5, 16'h0000, 14'h123, 32'h8000_0001, 1'b1},
        '{1'b1, 2'd1, 2'd1, 4'd5, 16'h00AA, 14'h123, 32'hDEAD_BEEF, 1'b1}
    };

    wr_err_injector dut (
        .clk(clk), .rst_n(rst_n), .cfg_wide_dimm(cfg_wide_dimm),
        .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .req_valid(req_valid), .req_write(req_write), .req_dimm(req_dimm),
        .req_rank(req_rank), .req_bank(req_bank), .req_page(req_page),
        .req_col(req_col), .req_check(req_check), .out_valid(out_valid),
        .out_check(out_check), .out_addr_par_err(out_addr_par_err),
        .inject_fired(inject_fired), .armed(armed)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Build a match word from the documented field positions.
    function automatic logic [41:0] mk_match(input logic wide, input logic [1:0] dimm,
        input logic [1:0] rank, input logic [3:0] bank, input logic [15:0] page,
        input logic [13:0] col, input logic [4:0] wild);
        logic [41:0] m;
        m = '0;
        m[13:0]  = col;
        m[29:14] = page;
        m[33:30] = bank;
        if (wide) begin
            m[36:35] = dimm;
            m[34]    = rank[0];
        end else begin
            m[36]    = dimm[0];
            m[35:34] = rank;
        end
        m[41:37] = wild;   // {dimm, rank, bank, page, col}
        return m;
    endfunction

    task automatic reg_write(input logic [1:0] sel, input logic [41:0] data);
        reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_sel = 2'd3; reg_wdata = '0;
    endtask

    // Present one request, return the outputs one cycle later.
    task automatic send(input logic wr, input logic [1:0] dimm, input logic [1:0] rank,
        input logic [3:0] bank, input logic [15:0] page, input logic [13:0] col,
        input logic [31:0] chk, output logic fired, output logic [31:0] ochk,
        output logic par, output logic ovld);
        req_valid = 1'b1; req_write = wr; req_dimm = dimm; req_rank = rank;
        req_bank = bank; req_page = page; req_col = col; req_check = chk;
        @(negedge clk);
        fired = inject_fired; ochk = out_check; par = out_addr_par_err; ovld = out_valid;
        req_valid = 1'b0; req_write = 1'b0; req_check = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic f, p, v;
        logic [31:0] c;
        rst_n = 1'b0; cfg_wide_dimm = 1'b0; reg_wr_en = 1'b0; reg_sel = 2'd3;
        reg_wdata = '0; req_valid = 1'b0; req_write = 1'b0; req_dimm = '0;
        req_rank = '0; req_bank = '0; req_page = '0; req_col = '0; req_check = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 out_valid", out_valid, 0);
        check("R1 armed", armed, 0);
        check("R1 inject_fired", inject_fired, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 wildcards after reset + R10 lower half + R8 one-shot
        reg_write(2'd1, {10'd0, MASK});
        reg_write(2'd2, 42'h0A);             // ecc, lower half, one-shot
        check("R5 armed after ctrl", armed, 1);
        send(1, 2'd2, 2'd3, 4'd9, 16'hBEEF, 14'h3FFF, 32'h1111_2222, f, c, p, v);
        check("R1 reset match any", f, 1);
        check("R10 lower half only", c, 32'h1111_2222 ^ 32'h0000_0F00);
        check("R2 valid after one cycle", v, 1);
        check("R8 disarmed after hit", armed, 0);
        send(1, 2'd2, 2'd3, 4'd9, 16'hBEEF, 14'h3FFF, 32'h1111_2222, f, c, p, v);
        check("R8 second write no fire", f, 0);
        check("R8 second write untouched", c, 32'h1111_2222);
        @(negedge clk);
        check("R12 pulse one cycle", inject_fired, 0);

        // R5 control with no error request stays disarmed
        reg_write(2'd2, 42'h07);
        check("R5 no error bits", armed, 0);

        // Vector table: repeat mode, full line
        reg_write(2'd0, mk_match(0, 2'd1, 2'd0, 4'd5, 16'h0, 14'h123, 5'b01010));
        reg_write(2'd2, 42'h0F);
        for (int i = 0; i < 8; i++) begin
            send(VECS[i].wr, VECS[i].dimm, VECS[i].rank, VECS[i].bank, VECS[i].page,
                 VECS[i].col, VECS[i].chk, f, c, p, v);
            check($sformatf("R3/R9 vec%0d fire", i), f, VECS[i].fire);
            check($sformatf("R10 vec%0d check", i), c,
                  VECS[i].fire ? (VECS[i].chk ^ MASK) : VECS[i].chk);
            check($sformatf("R11 vec%0d no parity", i), p, 0);
        end
        check("R9 still armed", armed, 1);
        reg_write(2'd2, 42'h00);
        check("R9 cleared", armed, 0);
        send(1, 2'd1, 2'd0, 4'd5, 16'h0, 14'h123, 32'h5, f, c, p, v);
        check("R9 no fire after clear", f, 0);

        // R7 read does not disarm a one-shot
        reg_write(2'd2, 42'h0C);             // ecc, upper half, one-shot
        send(0, 2'd1, 2'd0, 4'd5, 16'h0, 14'h123, 32'hCAFE_F00D, f, c, p, v);
        check("R7 read no fire", f, 0);
        check("R7 read armed kept", armed, 1);
        send(1, 2'd1, 2'd0, 4'd5, 16'h0, 14'h123, 32'hCAFE_F00D, f, c, p, v);
        check("R10 upper half", c, 32'hCAFE_F00D ^ 32'h00FF_0000);

        // R10 half select 00: fires but no flip
        reg_write(2'd2, 42'h08);
        send(1, 2'd1, 2'd0, 4'd5, 16'h0, 14'h123, 32'h0000_00FF, f, c, p, v);
        check("R10 none fires", f, 1);
        check("R10 none unchanged", c, 32'h0000_00FF);

        // R11 parity only
        reg_write(2'd2, 42'h10);
        send(1, 2'd1, 2'd0, 4'd5, 16'h0, 14'h123, 32'h1234_0000, f, c, p, v);
        check("R11 parity flag", p, 1);
        check("R11 parity check bits", c, 32'h1234_0000);

        // R6 match/flip write disarms
        reg_write(2'd2, 42'h1F);
        reg_write(2'd1, {10'd0, MASK});
        check("R6 flip write disarms", armed, 0);
        send(1, 2'd1, 2'd0, 4'd5, 16'h0, 14'h123, 32'h0, f, c, p, v);
        check("R6 no fire after disarm", f, 0);
        reg_write(2'd2, 42'h1F);
        reg_write(2'd3, 42'h0);
        check("R6 sel none keeps armed", armed, 1);
        reg_write(2'd0, mk_match(0, 2'd1, 2'd0, 4'd5, 16'h0, 14'h123, 5'b01010));
        check("R6 match write disarms", armed, 0);

        // R4 wide dimm layout
        cfg_wide_dimm = 1'b1;
        reg_write(2'd0, mk_match(1, 2'd2, 2'd1, 4'd0, 16'h0, 14'h0, 5'b00111));
        reg_write(2'd2, 42'h0F);
        send(1, 2'd2, 2'd1, 4'd7, 16'h77, 14'h7, 32'h0, f, c, p, v);
        check("R4 wide hit", f, 1);
        send(1, 2'd2, 2'd3, 4'd7, 16'h77, 14'h7, 32'h0, f, c, p, v);
        check("R4 wide rank bit1 ignored", f, 1);
        send(1, 2'd2, 2'd0, 4'd7, 16'h77, 14'h7, 32'h0, f, c, p, v);
        check("R4 wide rank miss", f, 0);
        send(1, 2'd3, 2'd1, 4'd7, 16'h77, 14'h7, 32'h0, f, c, p, v);
        check("R4 wide dimm miss", f, 0);

        // R1 reset clears armed
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset disarms", armed, 0);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end
endmodule